// File: doc/BRIEF.md
# I2C General Call Handler

This block is the slave-side decoder for transfers sent to the reserved all-zero I2C address. It sits behind a bit-level receiver that supplies byte-received strobes along with start and stop detects. For every received byte it returns a registered acknowledge decision. When a general call carries an address-change command, it rewrites the node's own 7-bit address. When that command also asks for a reset, it raises a reset request after the bus is released.

The byte that follows the general-call address selects the action:
- An odd value is a hardware general call. Bits 7:1 of that byte name the calling master.
- The value 0x06 means rewrite the own address and reset.
- The value 0x04 means rewrite the own address only.
- Any other even value is refused.

Four sticky status flags report which action took place and whether an access is in progress. The host clears the flags when it begins new work.

Top module: `gc_handler`

## Requirements
- R1: The byte after a start is treated as the address byte. When general call is enabled, the address byte 0x00 is acknowledged and sets the busy flag (status bit 0). Any other address byte, including 0x01, is not acknowledged and sets no flag.
- R2: While `gc_en_i` is low, no byte is acknowledged and no flag is set.
- R3: A second byte of 0x06 is acknowledged. The third byte is then acknowledged, the own address becomes bits 7:1 of that third byte, and the address-change flag (bit 1) and reset flag (bit 2) are both set.
- R4: A second byte of 0x04 behaves like R3, except that the reset flag stays clear and no reset request is ever raised.
- R5: A second byte that is even but is neither 0x04 nor 0x06 (0x00 included) is not acknowledged. Every later byte of that transfer is also refused, and neither the own address nor the action flags change.
- R6: A second byte with bit 0 set is acknowledged. It sets the hardware-call flag (bit 3) and loads bits 7:1 of that byte into `hw_master_o`. Later data bytes of the same transfer are acknowledged.
- R7: After the third byte of an address-change sequence, every further byte up to the next start or stop is not acknowledged.
- R8: When the transfer in which the reset flag was set ends with a stop, `reset_req_o` pulses for exactly one cycle, in the cycle after that stop is sampled. The pulse never comes earlier, so the node releases the bus lines before it resets.
- R9: A start or stop detect clears the busy flag in the following cycle and returns decoding to the address byte.
- R10: `host_clr_i` clears status bits 3..1 in the following cycle. The busy flag is not affected.
- R11: `ack_vld_o` pulses in the cycle after each sampled `byte_vld_i`, and `ack_o` carries the decision for that byte. After reset all status bits are 0, `reset_req_o` is low and the own address equals `OWN_ADDR_RST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gc_en_i | input | 1 | General-call response enable |
| start_det_i | input | 1 | Start or repeated start seen on the bus |
| stop_det_i | input | 1 | Stop seen on the bus |
| byte_vld_i | input | 1 | Strobe: a byte has been received |
| byte_i | input | 8 | Received byte |
| host_clr_i | input | 1 | Host strobe that clears the action flags |
| ack_vld_o | output | 1 | Acknowledge decision is valid |
| ack_o | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| own_addr_o | output | 7 | Current own slave address |
| hw_master_o | output | 7 | Address of the last hardware-call master |
| reset_req_o | output | 1 | One-cycle reset request |
| status_o | output | 4 | {hw call, reset, address change, busy} |

## Verification
The assertions check several rules on every cycle:
- each acknowledge pulse follows a received byte;
- nothing is acknowledged while general call is disabled;
- busy drops after any start or stop;
- the reset request comes only right after a stop, and only as a single pulse;
- the own address moves only together with an acknowledged byte that sets the address-change flag;
- every acknowledge happens with busy already set.

Some behaviour needs whole byte sequences and can only be shown by the bench scenarios. This covers the decoding of the command byte into its three actions, the refusal of unspecified or illegal codes and of bytes after the third, and the exact address value that is latched.

// File: rtl/gc_pkg.sv
package gc_pkg;
  typedef enum logic [2:0] {
    PH_ADDR, PH_CMD, PH_NEWADDR, PH_HWDATA, PH_IGNORE
  } gc_phase_e;

  typedef struct packed {
    logic hw;
    logic rst;
    logic addr;
    logic busy;
  } gc_flags_t;

  typedef struct packed {
    logic      ack;
    logic      set_busy;
    logic      set_hw;
    logic      set_addr;
    logic      set_rst;
    logic      arm_rst;
    logic      load_hw;
    logic      load_addr;
    gc_phase_e nxt;
  } gc_action_t;
endpackage

// File: rtl/gc_decode.sv
module gc_decode
  import gc_pkg::*;
#(
  parameter int          DATA_W       = 8,
  parameter logic [7:0]  CODE_RST     = 8'h06,
  parameter logic [7:0]  CODE_ADDR    = 8'h04
) (
  input  gc_phase_e         phase_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              gc_en_i,
  input  logic              rst_armed_i,
  output gc_action_t        act_o
);
  always_comb begin
    act_o     = '0;
    act_o.nxt = PH_IGNORE;
    if (gc_en_i) begin
      unique case (phase_i)
        PH_ADDR: begin
          if (byte_i == '0) begin
            act_o.ack      = 1'b1;
            act_o.set_busy = 1'b1;
            act_o.nxt      = PH_CMD;
          end
        end
        PH_CMD: begin
          if (byte_i[0]) begin
            act_o.ack     = 1'b1;
            act_o.set_hw  = 1'b1;
            act_o.load_hw = 1'b1;
            act_o.nxt     = PH_HWDATA;
          end else if (byte_i == DATA_W'(CODE_RST)) begin
            act_o.ack     = 1'b1;
            act_o.arm_rst = 1'b1;
            act_o.nxt     = PH_NEWADDR;
          end else if (byte_i == DATA_W'(CODE_ADDR)) begin
            act_o.ack     = 1'b1;
            act_o.nxt     = PH_NEWADDR;
          end
        end
        PH_NEWADDR: begin
          act_o.ack       = 1'b1;
          act_o.load_addr = 1'b1;
          act_o.set_addr  = 1'b1;
          act_o.set_rst   = rst_armed_i;
        end
        PH_HWDATA: begin
          act_o.ack = 1'b1;
          act_o.nxt = PH_HWDATA;
        end
        default: act_o.nxt = PH_IGNORE;
      endcase
    end
  end
endmodule

// File: rtl/gc_status.sv
module gc_status
  import gc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_evt_i,
  input  logic       host_clr_i,
  input  logic       take_i,
  input  gc_action_t act_i,
  output gc_flags_t  flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
    end else begin
      // set has priority over the host clear
      if (take_i && act_i.set_hw)        flags_o.hw <= 1'b1;
      else if (host_clr_i)               flags_o.hw <= 1'b0;
      if (take_i && act_i.set_rst)       flags_o.rst <= 1'b1;
      else if (host_clr_i)               flags_o.rst <= 1'b0;
      if (take_i && act_i.set_addr)      flags_o.addr <= 1'b1;
      else if (host_clr_i)               flags_o.addr <= 1'b0;
      if (bus_evt_i)                     flags_o.busy <= 1'b0;
      else if (take_i && act_i.set_busy) flags_o.busy <= 1'b1;
    end
  end
endmodule

// File: rtl/gc_handler.sv
module gc_handler
  import gc_pkg::*;
#(
  parameter int         DATA_W       = 8,
  parameter logic [7:0] CODE_RST     = 8'h06,
  parameter logic [7:0] CODE_ADDR    = 8'h04,
  parameter logic [6:0] OWN_ADDR_RST = 7'h2A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gc_en_i,
  input  logic              start_det_i,
  input  logic              stop_det_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              host_clr_i,
  output logic              ack_vld_o,
  output logic              ack_o,
  output logic [DATA_W-2:0] own_addr_o,
  output logic [DATA_W-2:0] hw_master_o,
  output logic              reset_req_o,
  output logic [3:0]        status_o
);
  localparam int AW = DATA_W - 1;

  gc_phase_e  phase_q;
  logic       rst_armed_q, rst_pend_q;
  logic       bus_evt, take;
  gc_action_t act;
  gc_flags_t  flags;

  assign bus_evt = start_det_i | stop_det_i;
  assign take    = byte_vld_i & ~bus_evt;

  gc_decode #(
    .DATA_W   (DATA_W),
    .CODE_RST (CODE_RST),
    .CODE_ADDR(CODE_ADDR)
  ) u_dec (
    .phase_i    (phase_q),
    .byte_i     (byte_i),
    .gc_en_i    (gc_en_i),
    .rst_armed_i(rst_armed_q),
    .act_o      (act)
  );

  gc_status u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_evt_i (bus_evt),
    .host_clr_i(host_clr_i),
    .take_i    (take),
    .act_i     (act),
    .flags_o   (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_ADDR;
      rst_armed_q <= 1'b0;
    end else if (bus_evt) begin
      phase_q     <= PH_ADDR;
      rst_armed_q <= 1'b0;
    end else if (take) begin
      phase_q <= act.nxt;
      if (act.arm_rst) rst_armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_vld_o <= 1'b0;
      ack_o     <= 1'b0;
    end else begin
      ack_vld_o <= take;
      if (take) ack_o <= act.ack;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_addr_o  <= AW'(OWN_ADDR_RST);
      hw_master_o <= '0;
    end else if (take) begin
      if (act.load_addr) own_addr_o  <= byte_i[DATA_W-1:1];
      if (act.load_hw)   hw_master_o <= byte_i[DATA_W-1:1];
    end
  end

  // reset waits for the stop so no line is held low while resetting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pend_q  <= 1'b0;
      reset_req_o <= 1'b0;
    end else begin
      reset_req_o <= stop_det_i & rst_pend_q;
      if (stop_det_i)                  rst_pend_q <= 1'b0;
      else if (take && act.set_rst)    rst_pend_q <= 1'b1;
    end
  end

  assign status_o = flags;
endmodule

// File: rtl/gc_handler_chk.sv
module gc_handler_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       gc_en_i,
  input logic       start_det_i,
  input logic       stop_det_i,
  input logic       byte_vld_i,
  input logic       host_clr_i,
  input logic       ack_vld_o,
  input logic       ack_o,
  input logic [6:0] own_addr_o,
  input logic       reset_req_o,
  input logic [3:0] status_o
);
  a_r11_ack_follows_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_vld_o |-> $past(byte_vld_i));
  a_r2_no_ack_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_vld_o && !$past(gc_en_i)) |-> !ack_o);
  a_r9_busy_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_det_i || stop_det_i) |-> !status_o[0]);
  a_r8_req_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> $past(stop_det_i));
  a_r8_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |=> !reset_req_o);
  a_r3_addr_moves_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(own_addr_o) |-> (ack_vld_o && ack_o && status_o[1]));
  a_r1_ack_implies_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_vld_o && ack_o) |-> status_o[0]);
  a_r10_host_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(host_clr_i) && !$past(byte_vld_i)) |-> (status_o[3:1] == 3'b000));
endmodule

bind gc_handler gc_handler_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .gc_en_i    (gc_en_i),
  .start_det_i(start_det_i),
  .stop_det_i (stop_det_i),
  .byte_vld_i (byte_vld_i),
  .host_clr_i (host_clr_i),
  .ack_vld_o  (ack_vld_o),
  .ack_o      (ack_o),
  .own_addr_o (own_addr_o),
  .reset_req_o(reset_req_o),
  .status_o   (status_o)
);

// File: tb/tb_gc_handler.sv
module tb_gc_handler;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       gc_en_i = 1'b0, start_det_i = 1'b0, stop_det_i = 1'b0;
  logic       byte_vld_i = 1'b0, host_clr_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       ack_vld_o, ack_o, reset_req_o;
  logic [6:0] own_addr_o, hw_master_o;
  logic [3:0] status_o;

  int errors = 0;
  int checks = 0;
  logic exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gc_handler dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && ack_vld_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 actual=unexpected ack pulse expected=none");
      end else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, ack_o, e);
      end
    end
  end

  task automatic send(input logic [7:0] b, input logic exp_ack, input string req);
    exp_q.push_back(exp_ack);
    tag_q.push_back(req);
    @(negedge clk_i); byte_i = b; byte_vld_i = 1'b1;
    @(negedge clk_i); byte_vld_i = 1'b0;
  endtask

  task automatic bus_start();
    @(negedge clk_i); start_det_i = 1'b1;
    @(negedge clk_i); start_det_i = 1'b0;
  endtask

  task automatic bus_stop();
    @(negedge clk_i); stop_det_i = 1'b1;
    @(negedge clk_i); stop_det_i = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk_i); host_clr_i = 1'b1;
    @(negedge clk_i); host_clr_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 reset status", status_o, 0);
    chk("R11 reset addr", own_addr_o, 7'h2A);
    chk("R11 reset req", reset_req_o, 0);
    gc_en_i = 1'b1;

    // R3 reset-and-rewrite, then R7 and R8
    bus_start();
    send(8'h00, 1'b1, "R1");
    chk("R1 busy", status_o[0], 1);
    send(8'h06, 1'b1, "R3");
    send(8'hB4, 1'b1, "R3");
    chk("R3 addr", own_addr_o, 7'h5A);
    chk("R3 flags", status_o, 4'b0111);
    send(8'h55, 1'b0, "R7");
    chk("R8 no early req", reset_req_o, 0);
    @(negedge clk_i); stop_det_i = 1'b1;
    @(negedge clk_i); stop_det_i = 1'b0;
    chk("R8 req pulse", reset_req_o, 1);
    chk("R9 busy after stop", status_o[0], 0);
    @(negedge clk_i);
    chk("R8 req single", reset_req_o, 0);

    clear_flags();
    chk("R10 cleared", status_o, 0);

    // R4 rewrite only
    bus_start();
    send(8'h00, 1'b1, "R1");
    send(8'h04, 1'b1, "R4");
    send(8'h3C, 1'b1, "R4");
    chk("R4 addr", own_addr_o, 7'h1E);
    chk("R4 flags", status_o, 4'b0011);
    send(8'h3D, 1'b0, "R7");
    @(negedge clk_i); stop_det_i = 1'b1;
    @(negedge clk_i); stop_det_i = 1'b0;
    chk("R4 no req", reset_req_o, 0);
    @(negedge clk_i);
    chk("R4 no req later", reset_req_o, 0);
    clear_flags();

    // R5 illegal and unspecified codes
    bus_start();
    send(8'h00, 1'b1, "R1");
    send(8'h00, 1'b0, "R5");
    send(8'h12, 1'b0, "R5");
    chk("R5 flags", status_o[3:1], 0);
    chk("R5 addr kept", own_addr_o, 7'h1E);
    bus_start();
    chk("R9 busy after start", status_o[0], 0);
    send(8'h00, 1'b1, "R1");
    send(8'h08, 1'b0, "R5");
    send(8'h44, 1'b0, "R5");
    chk("R5 addr kept 2", own_addr_o, 7'h1E);
    chk("R5 flags 2", status_o[3:1], 0);

    // R6 hardware general call
    bus_start();
    send(8'h00, 1'b1, "R1");
    send(8'h91, 1'b1, "R6");
    chk("R6 master", hw_master_o, 7'h48);
    chk("R6 flag", status_o, 4'b1001);
    send(8'h77, 1'b1, "R6");
    send(8'h78, 1'b1, "R6");
    bus_stop();
    chk("R6 no req", reset_req_o, 0);
    clear_flags();

    // R1 foreign addresses
    bus_start();
    send(8'hA0, 1'b0, "R1");
    chk("R1 foreign no busy", status_o, 0);
    bus_start();
    send(8'h01, 1'b0, "R1");
    send(8'h06, 1'b0, "R1");
    chk("R1 read gc no busy", status_o, 0);

    // R2 disabled
    gc_en_i = 1'b0;
    bus_start();
    send(8'h00, 1'b0, "R2");
    send(8'h04, 1'b0, "R2");
    send(8'h22, 1'b0, "R2");
    chk("R2 no flags", status_o, 0);
    chk("R2 addr kept", own_addr_o, 7'h1E);
    bus_stop();

    repeat (3) @(negedge clk_i);
    chk("R11 all acks seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule